// File: doc/BRIEF.md
# Serial Control Port with Data-Ready Interrupt

This block is the slave end of a four-wire serial control link. A host uses it to write command bytes into an on-chip processor and to read response bytes back. Every transaction opens with a header byte: a 7-bit device address followed by a direction bit. After a write header, each following byte is assembled from the data-in pin and handed to the processor as a one-cycle `rx_valid` pulse. After a read header, bytes are taken from a 16-entry outbound queue and shifted out on the data-out pin.

The processor fills the queue through a valid/ready push port. `tx_ready` is low while the queue is full, and also once the current read has been marked final. A producer must hold `tx_valid` and `tx_data` until it sees `tx_ready` high at a clock edge. The receive side has no back-pressure, because a serial host cannot be stalled, so the consumer must take every `rx_valid` pulse.

The active-low interrupt tells the host that bytes are waiting. During a read it also marks the final byte: it rises at the seventh rising clock edge of a byte when nothing more is queued. The host then clocks out the last bit and raises chip select. Any bytes left in the queue are discarded at that point. Chip select, serial clock and data-in pass through two-flop synchronizers into the system clock domain.

Top module: `spi_ctrl_port`

## Requirements
- R1: The header byte is shifted in most significant bit first: bits 7..1 are the address and bit 0 is the direction (1 = read, 0 = write). If the address differs from parameter `DEV_ADDR` (default 0), the rest of the transaction is ignored: no `rx_valid` is produced, `miso` stays 0 and the queue keeps its contents.
- R2: In a write transaction, each following byte is sampled MSB first on rising serial clock edges. Its value is then delivered on `rx_data` with a single-cycle `rx_valid` pulse.
- R3: The outbound queue holds 16 bytes and delivers them in push order. A push is accepted only when `tx_valid` and `tx_ready` are both high, and `tx_ready` is low while the queue is full.
- R4: In a read, the first byte's MSB appears on `miso` after the falling edge that follows the direction bit. Later bits change only on falling edges. Successive bytes follow with no gap. `miso` is 0 outside a read.
- R5: Outside a read, `irq_n` is low exactly when the queue holds at least one byte.
- R6: In a read, at the 7th rising edge of each byte, `irq_n` goes high if the queue is empty and otherwise stays low. Once high it stays high, and `tx_ready` stays low, until chip select rises.
- R7: A chip-select rise that ends a read discards every byte still queued, so `irq_n` is high afterwards.
- R8: A chip-select rise in the middle of a byte resets the bit count, and a partly received write byte is never delivered.
- R9: After reset `irq_n` = 1, `miso` = 0, `rx_valid` = 0 and `tx_ready` = 1.
- R10: If a read needs a byte while the queue is empty, 0x00 is shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select from host, active low |
| sclk | input | 1 | Serial clock from host, idles low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| irq_n | output | 1 | Data-ready / last-byte interrupt, active low |
| tx_valid | input | 1 | Outbound byte offered |
| tx_ready | output | 1 | Outbound byte can be accepted |
| tx_data | input | 8 | Outbound byte |
| rx_valid | output | 1 | Received write byte strobe |
| rx_data | output | 8 | Received write byte |

## Verification
The bench first checks the interrupt around the final byte. It samples `irq_n` just before and just after the 7th rising edge of every read byte. A design that rose one edge late would leave the host reading stale bytes, and one that rose early would cut a response short. The bench fills the queue to 16 entries and then pushes once more, to catch an overflow that corrupts order. It ends a read with bytes still queued and then reads on an empty queue, to expose a missing flush or garbage data. It also aborts a write mid-byte and sends headers with the wrong address; a wrong design would then emit spurious receive strobes or lose queued bytes.

// File: rtl/spi_cp_pkg.sv
package spi_cp_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [1:0] {PH_HDR, PH_WR, PH_RD, PH_SKIP} phase_t;
endpackage

// File: rtl/spi_cp_sync.sv
module spi_cp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
      prev <= RST_VAL;
    end else begin
      pipe <= {pipe[STAGES-2:0], din};
      prev <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~prev;
  assign fall = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/spi_cp_fifo.sv
module spi_cp_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> empty); // R7
endmodule

// File: rtl/spi_cp_engine.sv
module spi_cp_engine
  import spi_cp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_lvl,
  input  logic  cs_rise,
  input  logic  sclk_rise,
  input  logic  sclk_fall,
  input  logic  mosi_lvl,
  input  logic  q_empty,
  input  byte_t q_data,
  input  logic  push_fire,
  output logic  pop,
  output logic  flush,
  output logic  rx_valid,
  output byte_t rx_data,
  output logic  miso,
  output logic  irq_n,
  output logic  rd_last
);
  phase_t     phase;
  logic [2:0] bit_cnt;
  byte_t      in_sh, tx_sh;
  logic       load_pend;
  logic       seventh_rise;

  assign seventh_rise = !cs_lvl && sclk_rise && (bit_cnt == 3'd6) && (phase == PH_RD);
  assign pop   = !cs_lvl && sclk_fall && (phase == PH_RD) && load_pend && !q_empty;
  assign flush = cs_rise && (phase == PH_RD);
  assign miso  = (phase == PH_RD) && tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_HDR;
      bit_cnt   <= '0;
      in_sh     <= '0;
      tx_sh     <= '0;
      load_pend <= 1'b0;
      rd_last   <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (cs_lvl) begin
        phase     <= PH_HDR;
        bit_cnt   <= '0;
        tx_sh     <= '0;
        load_pend <= 1'b0;
        rd_last   <= 1'b0;
      end else begin
        if (sclk_rise) begin
          in_sh   <= {in_sh[6:0], mosi_lvl};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            unique case (phase)
              PH_HDR: begin
                if (in_sh[6:0] == DEV_ADDR) begin
                  phase     <= mosi_lvl ? PH_RD : PH_WR;
                  load_pend <= mosi_lvl;
                end else begin
                  phase <= PH_SKIP;
                end
              end
              PH_WR: begin
                rx_valid <= 1'b1;
                rx_data  <= {in_sh[6:0], mosi_lvl};
              end
              PH_RD:   load_pend <= 1'b1;
              default: ;
            endcase
          end
          if (seventh_rise && q_empty && !push_fire) rd_last <= 1'b1;
        end
        if (sclk_fall && phase == PH_RD) begin
          if (load_pend) begin
            tx_sh     <= q_empty ? 8'h00 : q_data;
            load_pend <= 1'b0;
          end else begin
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n <= 1'b1;
    end else if (cs_rise) begin
      irq_n <= 1'b1;
    end else if (phase == PH_RD && !cs_lvl) begin
      if (seventh_rise) irq_n <= q_empty && !push_fire;
    end else begin
      irq_n <= q_empty;
    end
  end

  AST_IRQ_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_last && !cs_lvl) |=> irq_n); // R6
  AST_IRQ_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RD && !cs_lvl && !irq_n && !seventh_rise) |=> !irq_n); // R6
  AST_RX_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(!cs_lvl)); // R2
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> !miso); // R4
endmodule

// File: rtl/spi_ctrl_port.sv
module spi_ctrl_port
  import spi_cp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h00,
  parameter int         DEPTH       = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  output logic       miso,
  output logic       irq_n,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       rx_valid,
  output logic [7:0] rx_data
);
  logic  cs_lvl, cs_rise, cs_fall;
  logic  sclk_lvl, sclk_rise, sclk_fall;
  logic  mosi_lvl, mosi_rise, mosi_fall;
  logic  q_empty, q_full, pop, flush, rd_last, push_fire;
  byte_t q_data;

  spi_cp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs (
    .clk(clk), .rst_n(rst_n), .din(cs_n),
    .lvl(cs_lvl), .rise(cs_rise), .fall(cs_fall));
  spi_cp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk (
    .clk(clk), .rst_n(rst_n), .din(sclk),
    .lvl(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall));
  spi_cp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mosi (
    .clk(clk), .rst_n(rst_n), .din(mosi),
    .lvl(mosi_lvl), .rise(mosi_rise), .fall(mosi_fall));

  assign tx_ready  = !q_full && !rd_last;
  assign push_fire = tx_valid && tx_ready;

  spi_cp_fifo #(.DEPTH(DEPTH), .W(8)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push_fire), .din(tx_data),
    .pop(pop), .flush(flush), .dout(q_data), .empty(q_empty), .full(q_full));

  spi_cp_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_lvl(mosi_lvl),
    .q_empty(q_empty), .q_data(q_data), .push_fire(push_fire),
    .pop(pop), .flush(flush), .rx_valid(rx_valid), .rx_data(rx_data),
    .miso(miso), .irq_n(irq_n), .rd_last(rd_last));

  AST_TXREADY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_lvl) |=> ##1 (tx_ready || q_full)); // R6
endmodule

// File: tb/tb_spi_ctrl_port.sv
module tb_spi_ctrl_port;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic       miso, irq_n, tx_ready, rx_valid;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0, rx_data;

  int errors = 0, checks = 0;
  logic [7:0] exp_rx[$];
  logic [7:0] mdl_q[$];
  logic       done = 1'b0;

  always #2 clk = ~clk;

  spi_ctrl_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .irq_n(irq_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: received write bytes against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_rx.size() == 0) chk("R2 unexpected rx", {24'h0, rx_data}, 32'hFFFF);
      else chk("R2 rx byte", {24'h0, rx_data}, {24'h0, exp_rx.pop_front()});
    end
  end

  task automatic push(input logic [7:0] b, output logic acc);
    @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    acc = tx_ready;
    @(negedge clk);
    tx_valid = 1'b0;
    if (acc) mdl_q.push_back(b);
  endtask

  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi,
                      output logic irq_pre, output logic irq7);
    for (int i = 7; i >= 0; i--) begin
      mosi = mo[i];
      repeat (HALF) @(negedge clk);
      if (i == 1) irq_pre = irq_n;
      sclk = 1'b1;
      mi[i] = miso;
      if (i == 1) begin
        repeat (5) @(negedge clk);
        irq7 = irq_n;
        repeat (HALF - 5) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      sclk = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; repeat (HALF) @(negedge clk);
  endtask
  task automatic cs_hi();
    repeat (HALF) @(negedge clk); cs_n = 1'b1; repeat (10) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] mi, exp_b;
    logic ip, i7, acc;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk("R9 irq_n", irq_n, 1); chk("R9 miso", miso, 0);
    chk("R9 rx_valid", rx_valid, 0); chk("R9 tx_ready", tx_ready, 1);

    // R1 R2 write to matching address
    exp_rx.push_back(8'hA5); exp_rx.push_back(8'h3C);
    cs_lo(); xfer(8'h00, mi, ip, i7); xfer(8'hA5, mi, ip, i7); xfer(8'h3C, mi, ip, i7); cs_hi();
    chk("R2 all rx delivered", exp_rx.size(), 0);

    // R1 wrong address write: nothing delivered (monitor flags any rx)
    cs_lo(); xfer(8'h02, mi, ip, i7); xfer(8'h77, mi, ip, i7); cs_hi();

    // R5 irq low with data pending
    push(8'h11, acc); push(8'h22, acc); push(8'h33, acc);
    repeat (3) @(negedge clk);
    chk("R5 irq low pending", irq_n, 0);

    // R1 wrong address read: miso quiet, queue kept
    cs_lo(); xfer(8'h03, mi, ip, i7); xfer(8'h00, mi, ip, i7);
    chk("R1 miso quiet", mi, 8'h00); cs_hi();
    chk("R1 queue kept", irq_n, 0);

    // R4 R6 read three bytes
    cs_lo(); xfer(8'h01, mi, ip, i7);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, mi, ip, i7);
      exp_b = mdl_q.pop_front();
      chk("R4 read byte", mi, exp_b);
      chk("R6 irq low before 7th", ip, 0);
      chk("R6 irq at 7th edge", i7, (k == 2) ? 1 : 0);
    end
    chk("R6 tx_ready low after last", tx_ready, 0);
    cs_hi();
    chk("R5 irq high empty", irq_n, 1); chk("R6 tx_ready back", tx_ready, 1);

    // R3 fill to 16, extra push refused
    for (int k = 0; k < 16; k++) begin
      push(8'h40 + 8'(k), acc);
      chk("R3 push accepted", acc, 1);
    end
    push(8'hEE, acc);
    chk("R3 full refused", acc, 0);

    // R3 R7 read two, end with data queued
    cs_lo(); xfer(8'h01, mi, ip, i7);
    for (int k = 0; k < 2; k++) begin
      xfer(8'h00, mi, ip, i7);
      chk("R3 order", mi, mdl_q.pop_front());
      chk("R6 irq stays low", i7, 0);
    end
    cs_hi(); mdl_q.delete();
    chk("R7 flushed irq high", irq_n, 1);

    // R10 read on empty queue
    cs_lo(); xfer(8'h01, mi, ip, i7); xfer(8'h00, mi, ip, i7);
    chk("R10 zero byte", mi, 8'h00); chk("R10 irq high", i7, 1); cs_hi();

    // R8 partial write aborted
    cs_lo(); xfer(8'h00, mi, ip, i7);
    for (int i = 0; i < 4; i++) begin
      mosi = 1'b1; repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b0;
    end
    cs_hi();
    exp_rx.push_back(8'h5A);
    cs_lo(); xfer(8'h00, mi, ip, i7); xfer(8'h5A, mi, ip, i7); cs_hi();
    chk("R8 only full byte", exp_rx.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule